// File: doc/BRIEF.md
# Host Control-Link Slave Bridge

This block sits on the host side of a serial control link made of a bit clock, a data line, an enable line and two mode lines. It is a slave: it listens only while the host holds enable high. It takes in 16-bit settings words and 8-bit extended settings bytes, and holds each one in its own register until a downstream forwarder accepts it through a request and acknowledge handshake. It also answers status reads with a cached copy of the codec status word. In that reply, two bits are replaced by the block's own ready flags, one for each holding register.

The link signals are asynchronous to the system clock. They pass through a synchronizer and are edge-detected. Data moves in 8-bit units, least significant bit first. A 16-bit item is sent as two units, upper byte first, and enable stays high between the two units. The mode is taken from the mode lines when enable rises. A host must see the matching ready flag at 1 before it writes. A write that arrives while the flag is 0 is dropped and sets a sticky overrun indicator.

Top module: `ctl_link_bridge`

## Requirements
- R1: While the synchronized enable is low, clock edges and data on the link have no effect. Nothing is accepted and the data line is not driven.
- R2: Mode 2'b10 is a settings write of 16 clock edges. The first eight bits land in word bits 8..15 and the next eight in bits 0..7, each byte least significant bit first. The word is presented on `set_fwd_data` with `set_fwd_req` high.
- R3: Mode 2'b00 is an extended settings write of 8 bits, least significant bit first. The byte is forwarded unaltered on `ext_fwd_data` with `ext_fwd_req` high.
- R4: Mode 2'b11 is a status read. The reply word is captured when enable rises and is sent in the order of bits 8..15 and then 0..7. Bits 15..10 and 7..0 come from the cached status, which changes only on a `sts_load` pulse.
- R5: In the status reply, bit 9 is the settings-ready flag and bit 8 is the extended-settings-ready flag. Each flag is 1 when its register is free.
- R6: After a write is accepted, its ready flag reads 0 and its request stays high with stable data until an acknowledge arrives. After the acknowledge, the flag returns to 1 and the request drops.
- R7: A complete write that arrives while its ready flag is 0 is discarded and leaves the held data unchanged. It also sets `host_overrun`, which stays set until reset.
- R8: `lk_dat_oe` is high only during a status read with enable high. It returns low after enable falls.
- R9: A status read may end after 8 bits. Those 8 bits carry reply bits 8..15, including both ready flags, and the next transfer then works normally.
- R10: A write cut short by enable falling before its last bit is discarded. It raises no request and no overrun.
- R11: Mode 2'b01 transfers from the host are ignored.
- R12: After reset, both ready flags are 1, both requests are low, `host_overrun` is 0 and `lk_dat_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_clk | input | 1 | Link bit clock from the host, idle high, sampled on rising edges |
| lk_en | input | 1 | Link enable from the host |
| lk_mode | input | 2 | Link mode lines, taken when enable rises |
| lk_dat_i | input | 1 | Link data from the host |
| lk_dat_o | output | 1 | Link data toward the host during status reads |
| lk_dat_oe | output | 1 | Output enable for the link data pad |
| sts_in | input | 16 | Codec status word |
| sts_load | input | 1 | Pulse that refreshes the cached status |
| set_fwd_req | output | 1 | Settings word waiting to be forwarded |
| set_fwd_data | output | 16 | Held settings word |
| set_fwd_ack | input | 1 | Downstream has taken the settings word |
| ext_fwd_req | output | 1 | Extended settings byte waiting to be forwarded |
| ext_fwd_data | output | 8 | Held extended settings byte |
| ext_fwd_ack | input | 1 | Downstream has taken the extended byte |
| host_overrun | output | 1 | Sticky flag: a write arrived while its register was busy |

## Verification
The assertions assume three things about the inputs. Each link clock phase lasts longer than the synchronizer delay plus one cycle. The mode lines are settled before enable rises. An acknowledge is given only while its request is high. Under these assumptions, a held request and its data cannot move, and the pad is never driven without enable. The stimulus meets them with link half-periods of eight system cycles and mode changes three cycles before enable. Acknowledges are one-cycle pulses, issued only after the bench has seen the request high.

// File: rtl/clb_pkg.sv
package clb_pkg;

    localparam int WORD_W   = 16;
    localparam int UNIT_W   = 8;
    localparam int CNT_W    = $clog2(WORD_W) + 1;
    localparam int SET_RDY  = 9;
    localparam int EXT_RDY  = 8;

    typedef enum logic [1:0] {
        MD_EXT   = 2'b00,
        MD_ALLOC = 2'b01,
        MD_SET   = 2'b10,
        MD_STAT  = 2'b11
    } lk_mode_e;

    // Serial engine state
    typedef struct packed {
        logic              en_prev;
        logic              clk_prev;
        logic              active;
        lk_mode_e          mode;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] tx;
    } eng_t;

    // Top-level state
    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic              ovr;
    } top_t;

    // Wire order: bit k of the transfer maps to word bit 8..15 then 0..7
    function automatic logic [3:0] wire_pos(input logic [3:0] k);
        return {~k[3], k[2:0]};
    endfunction

endpackage

// File: rtl/clb_sync.sv
module clb_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/clb_engine.sv
module clb_engine
    import clb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              clk_s,
    input  logic [1:0]        mode_s,
    input  logic              dat_s,
    input  logic [WORD_W-1:0] reply_word,
    output logic              wr_set,
    output logic              wr_ext,
    output logic [WORD_W-1:0] wr_word,
    output logic              dat_o,
    output logic              dat_oe
);

    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] LAST_UNIT = CNT_W'(UNIT_W - 1);
    localparam logic [CNT_W-1:0] FULL      = CNT_W'(WORD_W);

    eng_t q, d;
    logic en_rise, en_fall, clk_rise;
    logic [3:0] rpos, tpos;

    always_comb begin
        d        = q;
        wr_set   = 1'b0;
        wr_ext   = 1'b0;
        en_rise  = en_s & ~q.en_prev;
        en_fall  = ~en_s & q.en_prev;
        clk_rise = clk_s & ~q.clk_prev;
        rpos     = wire_pos(q.cnt[3:0]);
        d.en_prev  = en_s;
        d.clk_prev = clk_s;

        if (en_rise) begin
            d.active = 1'b1;
            d.mode   = lk_mode_e'(mode_s);
            d.cnt    = '0;
            d.rx     = '0;
            d.tx     = reply_word;
        end else if (en_fall) begin
            d.active = 1'b0;
        end else if (q.active && en_s && clk_rise && (q.cnt < FULL)) begin
            d.cnt = q.cnt + 1'b1;
            if (q.mode == MD_SET || q.mode == MD_EXT) begin
                d.rx[rpos] = dat_s;
            end
            if (q.mode == MD_SET && q.cnt == LAST_WORD) wr_set = 1'b1;
            if (q.mode == MD_EXT && q.cnt == LAST_UNIT) wr_ext = 1'b1;
        end
        wr_word = d.rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{en_prev: 1'b0, clk_prev: 1'b0, active: 1'b0,
                   mode: MD_EXT, cnt: '0, rx: '0, tx: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        tpos   = wire_pos(q.cnt[3:0]);
        dat_o  = q.tx[tpos];
        dat_oe = q.active & en_s & (q.mode == MD_STAT);
    end

endmodule

// File: rtl/clb_slot.sv
module clb_slot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         ack,
    output logic         req,
    output logic [W-1:0] data,
    output logic         rdy,
    output logic         reject
);

    typedef struct packed {
        logic         pend;
        logic [W-1:0] hold;
    } slot_t;

    slot_t q, d;

    always_comb begin
        d      = q;
        reject = 1'b0;
        if (wr) begin
            if (q.pend) begin
                reject = 1'b1;
            end else begin
                d.pend = 1'b1;
                d.hold = wr_data;
            end
        end
        if (ack && q.pend) begin
            d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{pend: 1'b0, hold: '0};
        else        q <= d;
    end

    assign req  = q.pend;
    assign data = q.hold;
    assign rdy  = ~q.pend;

endmodule

// File: rtl/ctl_link_bridge.sv
module ctl_link_bridge
    import clb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_clk,
    input  logic              lk_en,
    input  logic [1:0]        lk_mode,
    input  logic              lk_dat_i,
    output logic              lk_dat_o,
    output logic              lk_dat_oe,
    input  logic [WORD_W-1:0] sts_in,
    input  logic              sts_load,
    output logic              set_fwd_req,
    output logic [WORD_W-1:0] set_fwd_data,
    input  logic              set_fwd_ack,
    output logic              ext_fwd_req,
    output logic [UNIT_W-1:0] ext_fwd_data,
    input  logic              ext_fwd_ack,
    output logic              host_overrun
);

    localparam int SYNC_W = 5;

    logic [SYNC_W-1:0] raw, synced;
    logic              en_s, clk_s, dat_s;
    logic [1:0]        mode_s;
    logic              wr_set, wr_ext;
    logic [WORD_W-1:0] wr_word, reply_word;
    logic              set_rdy, ext_rdy, rej_set, rej_ext;
    top_t              q, d;

    assign raw = {lk_en, lk_clk, lk_mode, lk_dat_i};

    clb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (synced)
    );

    assign {en_s, clk_s, mode_s, dat_s} = synced;

    always_comb begin
        reply_word          = q.stat;
        reply_word[SET_RDY] = set_rdy;
        reply_word[EXT_RDY] = ext_rdy;
    end

    clb_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_s      (en_s),
        .clk_s     (clk_s),
        .mode_s    (mode_s),
        .dat_s     (dat_s),
        .reply_word(reply_word),
        .wr_set    (wr_set),
        .wr_ext    (wr_ext),
        .wr_word   (wr_word),
        .dat_o     (lk_dat_o),
        .dat_oe    (lk_dat_oe)
    );

    clb_slot #(.W(WORD_W)) u_set (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_set),
        .wr_data(wr_word),
        .ack    (set_fwd_ack),
        .req    (set_fwd_req),
        .data   (set_fwd_data),
        .rdy    (set_rdy),
        .reject (rej_set)
    );

    clb_slot #(.W(UNIT_W)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ext),
        .wr_data(wr_word[WORD_W-1:WORD_W-UNIT_W]),
        .ack    (ext_fwd_ack),
        .req    (ext_fwd_req),
        .data   (ext_fwd_data),
        .rdy    (ext_rdy),
        .reject (rej_ext)
    );

    always_comb begin
        d      = q;
        d.stat = sts_load ? sts_in : q.stat;
        d.ovr  = q.ovr | rej_set | rej_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{stat: '0, ovr: 1'b0};
        else        q <= d;
    end

    assign host_overrun = q.ovr;

endmodule

// File: rtl/clb_checks.sv
module clb_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        en_s,
    input logic        lk_dat_oe,
    input logic        wr_set,
    input logic        wr_ext,
    input logic        set_fwd_req,
    input logic        set_fwd_ack,
    input logic [15:0] set_fwd_data,
    input logic        ext_fwd_req,
    input logic        ext_fwd_ack,
    input logic [7:0]  ext_fwd_data,
    input logic        host_overrun
);

    // R1: no write pulse leaves the engine while enable is low
    a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |-> !(wr_set || wr_ext));

    // R8: the pad is driven only with enable high
    a_r8_oe_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dat_oe |-> en_s);

    // R6: settings request holds with stable data until acknowledged
    a_r6_set_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fwd_req && !set_fwd_ack) |=> set_fwd_req);
    a_r6_set_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (set_fwd_req && !set_fwd_ack) |=> $stable(set_fwd_data));

    // R6: extended request holds with stable data until acknowledged
    a_r6_ext_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_fwd_req && !ext_fwd_ack) |=> ext_fwd_req);
    a_r6_ext_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_fwd_req && !ext_fwd_ack) |=> $stable(ext_fwd_data));

    // R7: overrun is sticky
    a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        host_overrun |=> host_overrun);

endmodule

bind ctl_link_bridge clb_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_s        (en_s),
    .lk_dat_oe   (lk_dat_oe),
    .wr_set      (wr_set),
    .wr_ext      (wr_ext),
    .set_fwd_req (set_fwd_req),
    .set_fwd_ack (set_fwd_ack),
    .set_fwd_data(set_fwd_data),
    .ext_fwd_req (ext_fwd_req),
    .ext_fwd_ack (ext_fwd_ack),
    .ext_fwd_data(ext_fwd_data),
    .host_overrun(host_overrun)
);

// File: tb/sim_ctl_link_bridge.sv
`timescale 1ns/1ps
module sim_ctl_link_bridge;

    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_clk = 1'b1, lk_en = 1'b0, lk_dat_i = 1'b0;
    logic [1:0]  lk_mode = 2'b00;
    logic        lk_dat_o, lk_dat_oe;
    logic [15:0] sts_in = '0;
    logic        sts_load = 1'b0;
    logic        set_fwd_req, set_fwd_ack = 1'b0;
    logic [15:0] set_fwd_data;
    logic        ext_fwd_req, ext_fwd_ack = 1'b0;
    logic [7:0]  ext_fwd_data;
    logic        host_overrun;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic oe_all;

    always #10 clk = ~clk;

    ctl_link_bridge u0 (.*);

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end

    task automatic lk_open(input logic [1:0] m);
        lk_mode = m; wait_cyc(3);
        lk_en = 1'b1; wait_cyc(HP);
    endtask

    task automatic lk_close;
        lk_en = 1'b0; wait_cyc(4*HP);
    endtask

    // One bit: fall, drive, sample before rise, rise
    task automatic lk_bit(input logic b, output logic r);
        lk_clk = 1'b0; lk_dat_i = b; wait_cyc(HP);
        r = lk_dat_o; oe_all &= lk_dat_oe;
        lk_clk = 1'b1; wait_cyc(HP);
    endtask

    task automatic shift(input logic [15:0] w, input int nbits, output logic [15:0] got);
        logic r;
        got = '0; oe_all = 1'b1;
        for (int k = 0; k < nbits; k++) begin
            logic [3:0] p;
            p = {~k[3], k[2:0]};
            lk_bit(w[p], r);
            got[p] = r;
            if (k == 7) wait_cyc(2*HP);
        end
    endtask

    task automatic write(input logic [1:0] m, input logic [15:0] w, input int nbits);
        logic [15:0] dummy;
        lk_open(m); shift(w, nbits, dummy); lk_close();
    endtask

    task automatic read(input int nbits, output logic [15:0] v, output logic oe);
        lk_open(2'b11); shift(16'h0000, nbits, v); oe = oe_all; lk_close();
    endtask

    task automatic pulse_set_ack;
        set_fwd_ack = 1'b1; wait_cyc(1); set_fwd_ack = 1'b0; wait_cyc(2);
    endtask

    task automatic pulse_ext_ack;
        ext_fwd_ack = 1'b1; wait_cyc(1); ext_fwd_ack = 1'b0; wait_cyc(2);
    endtask

    task automatic t_reset;
        logic [15:0] v; logic oe;
        check("R12 ready/req/ovr/oe", {12'h0, set_fwd_req, ext_fwd_req, host_overrun, lk_dat_oe}, 16'h0);
        sts_in = 16'hA5C3; sts_load = 1'b1; wait_cyc(1); sts_load = 1'b0; wait_cyc(2);
        read(16, v, oe);
        check("R4 R5 R12 status with both ready", v, 16'hA7C3);
        check("R8 oe during read", {15'h0, oe}, 16'h1);
        check("R8 oe released", {15'h0, lk_dat_oe}, 16'h0);
    endtask

    task automatic t_idle;
        logic r;
        for (int i = 0; i < 20; i++) begin
            lk_bit(i[0], r);
            check("R1 no drive while enable low", {15'h0, lk_dat_oe}, 16'h0);
        end
        wait_cyc(HP);
        check("R1 no request", {14'h0, set_fwd_req, ext_fwd_req}, 16'h0);
    endtask

    task automatic t_sts_load_only;
        logic [15:0] v; logic oe;
        sts_in = 16'hFFFF; wait_cyc(4);
        read(16, v, oe);
        check("R4 cache unchanged without load", v, 16'hA7C3);
        sts_in = 16'hA5C3; sts_load = 1'b1; wait_cyc(1); sts_load = 1'b0; wait_cyc(2);
    endtask

    task automatic t_partial_and_alloc;
        write(2'b10, 16'h1234, 5);
        check("R10 short write no request", {15'h0, set_fwd_req}, 16'h0);
        check("R10 short write no overrun", {15'h0, host_overrun}, 16'h0);
        write(2'b01, 16'hFFFF, 16);
        check("R11 alloc mode ignored", {13'h0, set_fwd_req, ext_fwd_req, host_overrun}, 16'h0);
    endtask

    task automatic t_settings;
        logic [15:0] v; logic oe;
        write(2'b10, 16'h1234, 16);
        check("R2 settings request", {15'h0, set_fwd_req}, 16'h1);
        check("R2 settings data", set_fwd_data, 16'h1234);
        read(16, v, oe);
        check("R6 R5 settings flag low while pending", v, 16'hA5C3);
        pulse_set_ack();
        check("R6 request drops after ack", {15'h0, set_fwd_req}, 16'h0);
        read(16, v, oe);
        check("R6 settings flag back to 1", v, 16'hA7C3);
    endtask

    task automatic t_ext;
        logic [15:0] v; logic oe;
        write(2'b00, 16'h5A00, 8);
        check("R3 ext request", {15'h0, ext_fwd_req}, 16'h1);
        check("R3 ext data", {8'h0, ext_fwd_data}, 16'h005A);
        read(8, v, oe);
        check("R9 R5 short read first byte", {8'h0, v[15:8]}, 16'h00A6);
        pulse_ext_ack();
        read(16, v, oe);
        check("R9 next read after short read", v, 16'hA7C3);
    endtask

    task automatic t_overrun;
        write(2'b10, 16'hBEEF, 16);
        check("R2 second word accepted", set_fwd_data, 16'hBEEF);
        write(2'b10, 16'h0F0F, 16);
        check("R7 busy write discarded", set_fwd_data, 16'hBEEF);
        check("R7 overrun set", {15'h0, host_overrun}, 16'h1);
        pulse_set_ack();
        wait_cyc(5);
        check("R7 overrun sticky", {15'h0, host_overrun}, 16'h1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(3);
        t_reset();
        t_idle();
        t_sts_load_only();
        t_partial_and_alloc();
        t_settings();
        t_ext();
        t_overrun();
        finish_run();
    end

endmodule